// File: doc/BRIEF.md
# Multi-Function Timer with Periodic Interrupt

This block is a free-running divider chain clocked by the bus clock. It keeps counting while the processor sits in its low-power wait state. A divide-by-four prescaler advances an 8-bit up-counter, and software can read that counter at any moment. Each time the 8-bit counter wraps, an overflow flag is raised, so the flag rises once every 1024 bus cycles.

The carry out of the 8-bit counter drives a 7-bit upper counter. The last four stages of the upper counter serve as taps for a periodic interrupt. A 2-bit rate field picks one tap, which gives a period of 2^14, 2^15, 2^16 or 2^17 bus cycles. Each flag holds until software acknowledges it. Each flag can raise an interrupt request when its enable bit is set.

There are two registers, and the select input picks between them. It is the low address bit: 0 selects the control/status register and 1 selects the counter register. A synchronous clear from reset empties the whole chain and the register state.

Top module: `mft_timer`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears the chain, both flags, both enables and the rate field. Counting then restarts from zero: after N edges with `rst` low, the counter register reads (N/4) mod 256.
- R2: With `reg_sel`=1, `rd_data` returns the 8-bit counter. The counter advances by one every fourth bus cycle and wraps from 255 to 0.
- R3: The overflow flag (control bit 7) sets on the edge where the low 10 chain bits wrap, which is every 1024 bus cycles after reset. It stays set until it is acknowledged.
- R4: The periodic flag (control bit 6) sets on the edge where the low 14+`rate` chain bits wrap. With `rate` in bits 1:0, the period is 2^14 for 00, 2^15 for 01, 2^16 for 10 and 2^17 for 11 bus cycles.
- R5: A control write with bit 3 set clears the overflow flag, and a control write with bit 2 set clears the periodic flag. If the flag's own event occurs in that same cycle, the flag stays set.
- R6: `irq_ovf` is high exactly when the overflow flag and the overflow enable (bit 5) are both set. `irq_per` is high exactly when the periodic flag and the periodic enable (bit 4) are both set. Clearing an enable bit does not change its flag.
- R7: A change of `rate` takes effect at the next boundary of the newly selected period. A boundary of the previous setting that falls after the change does not set the periodic flag.
- R8: The control register reads back as {ovf flag, per flag, ovf enable, per enable, 0, 0, rate}. The acknowledge bits always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock (runs during wait mode) |
| rst | input | 1 | Synchronous clear of chain and registers |
| reg_sel | input | 1 | 0 selects control/status, 1 selects the counter |
| wr_en | input | 1 | Write strobe for the control/status register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_per | output | 1 | Periodic interrupt request |

## Verification
After N edges without reset, the counter register holds (N/4) mod 256. An overflow or periodic flag shows on the same edge that brings the chain to a multiple of its period. A control write acts on the edge that samples it. The interrupt outputs follow the flags and enables in that same cycle with no extra register. The bench counts every edge after reset is released and changes inputs only at falling edges. It samples one time unit after each falling edge, so every comparison sees the state left by a known number of edges. For each flag it checks the cycle just before the boundary and the boundary cycle itself, which pins the setting edge exactly.

// File: rtl/mft_pkg.sv
package mft_pkg;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flg_state_t;

    localparam int CTL_OVF_FLG = 7;
    localparam int CTL_PER_FLG = 6;
    localparam int CTL_OVF_EN  = 5;
    localparam int CTL_PER_EN  = 4;
    localparam int CTL_OVF_ACK = 3;
    localparam int CTL_PER_ACK = 2;

endpackage

// File: rtl/mft_chain.sv
module mft_chain #(
    parameter int PRE_W  = 2,
    parameter int LO_W   = 8,
    parameter int HI_W   = 7,
    parameter int RATE_W = 2,
    localparam int CHAIN_W  = PRE_W + LO_W + HI_W,
    localparam int NUM_TAPS = 1 << RATE_W,
    localparam int TAP_BASE = CHAIN_W - NUM_TAPS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATE_W-1:0]  rate,
    output logic [CHAIN_W-1:0] chain,
    output logic [LO_W-1:0]    count,
    output logic               ovf_evt,
    output logic               per_evt
);

    logic [CHAIN_W-1:0]  chain_q;
    logic [NUM_TAPS-1:0] tap_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_q + 1'b1;
        end
    end

    // One wrap detector per selectable period; the rate field picks one.
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        assign tap_wrap[t] = &chain_q[TAP_BASE + t:0];
    end

    assign chain   = chain_q;
    assign count   = chain_q[PRE_W + LO_W - 1:PRE_W];
    assign ovf_evt = &chain_q[PRE_W + LO_W - 1:0];
    assign per_evt = tap_wrap[rate];

endmodule

// File: rtl/mft_flag.sv
module mft_flag
    import mft_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic ack,
    output logic flag
);

    flg_state_t state_q;
    flg_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        flag    = 1'b0;
        unique case (state_q)
            FLG_IDLE: begin
                if (evt) begin
                    state_d = FLG_PEND;
                end
            end
            FLG_PEND: begin
                flag = 1'b1;
                if (ack && !evt) begin
                    state_d = FLG_IDLE;
                end
            end
            default: state_d = FLG_IDLE;
        endcase
    end

endmodule

// File: rtl/mft_timer.sv
module mft_timer
    import mft_pkg::*;
#(
    parameter int PRE_W  = 2,
    parameter int LO_W   = 8,
    parameter int HI_W   = 7,
    parameter int RATE_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_ovf,
    output logic              irq_per
);

    localparam int CHAIN_W = PRE_W + LO_W + HI_W;

    logic [CHAIN_W-1:0] chain_q;
    logic [LO_W-1:0]    count;
    logic               ovf_evt;
    logic               per_evt;
    logic               ovf_flag;
    logic               per_flag;
    logic               ovf_en_q;
    logic               per_en_q;
    logic [RATE_W-1:0]  rate_q;
    logic               ctl_wr;
    logic               ovf_ack;
    logic               per_ack;
    logic [DATA_W-1:0]  ctl_view;
    logic               unused_wr_hi;

    assign ctl_wr  = wr_en && !reg_sel;
    assign ovf_ack = ctl_wr && wr_data[CTL_OVF_ACK];
    assign per_ack = ctl_wr && wr_data[CTL_PER_ACK];
    assign unused_wr_hi = &{1'b0, wr_data[DATA_W-1:CTL_PER_EN+2]};

    mft_chain #(
        .PRE_W  (PRE_W),
        .LO_W   (LO_W),
        .HI_W   (HI_W),
        .RATE_W (RATE_W)
    ) u_chain (
        .clk     (clk),
        .rst     (rst),
        .rate    (rate_q),
        .chain   (chain_q),
        .count   (count),
        .ovf_evt (ovf_evt),
        .per_evt (per_evt)
    );

    mft_flag u_ovf_flag (
        .clk  (clk),
        .rst  (rst),
        .evt  (ovf_evt),
        .ack  (ovf_ack),
        .flag (ovf_flag)
    );

    mft_flag u_per_flag (
        .clk  (clk),
        .rst  (rst),
        .evt  (per_evt),
        .ack  (per_ack),
        .flag (per_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_en_q <= 1'b0;
            per_en_q <= 1'b0;
            rate_q   <= '0;
        end else if (ctl_wr) begin
            ovf_en_q <= wr_data[CTL_OVF_EN];
            per_en_q <= wr_data[CTL_PER_EN];
            rate_q   <= wr_data[RATE_W-1:0];
        end
    end

    always_comb begin
        ctl_view                = '0;
        ctl_view[CTL_OVF_FLG]   = ovf_flag;
        ctl_view[CTL_PER_FLG]   = per_flag;
        ctl_view[CTL_OVF_EN]    = ovf_en_q;
        ctl_view[CTL_PER_EN]    = per_en_q;
        ctl_view[RATE_W-1:0]    = rate_q;
    end

    assign rd_data = reg_sel ? DATA_W'(count) : ctl_view;
    assign irq_ovf = ovf_flag && ovf_en_q;
    assign irq_per = per_flag && per_en_q;

endmodule

// File: rtl/mft_timer_chk.sv
module mft_timer_chk #(
    parameter int PRE_W  = 2,
    parameter int LO_W   = 8,
    parameter int HI_W   = 7,
    parameter int RATE_W = 2,
    parameter int DATA_W = 8,
    localparam int CHAIN_W  = PRE_W + LO_W + HI_W,
    localparam int TAP_BASE = CHAIN_W - (1 << RATE_W)
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_sel,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wr_data,
    input logic [CHAIN_W-1:0] chain,
    input logic               ovf_flag,
    input logic               per_flag,
    input logic [RATE_W-1:0]  rate,
    input logic               irq_ovf,
    input logic               irq_per
);

    logic [CHAIN_W:0]   per_mask_w;
    logic [CHAIN_W-1:0] per_mask;
    logic               per_wrap;
    logic               ovf_wrap;
    logic               ack_o;
    logic               ack_p;
    logic               unused_chk;

    assign per_mask_w = ((CHAIN_W + 1)'(1) << (TAP_BASE + 1 + int'(rate))) - 1'b1;
    assign per_mask   = per_mask_w[CHAIN_W-1:0];
    assign per_wrap   = (chain & per_mask) == per_mask;
    assign ovf_wrap   = chain[PRE_W + LO_W - 1:0] == '1;
    assign ack_o      = wr_en && !reg_sel && wr_data[3];
    assign ack_p      = wr_en && !reg_sel && wr_data[2];
    assign unused_chk = &{1'b0, per_mask_w[CHAIN_W], wr_data};

    // R1: a reset edge leaves the chain and both flags cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (chain == '0) && !ovf_flag && !per_flag);

    // R2: the counter field only moves when the prescaler wraps
    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (chain[PRE_W-1:0] != '1) |=> $stable(chain[PRE_W + LO_W - 1:PRE_W]));

    // R3: the overflow boundary sets the flag
    p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_wrap |=> ovf_flag);

    // R3: the overflow flag holds unless acknowledged
    p_ovf_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ack_o) |=> ovf_flag);

    // R4: the selected boundary sets the periodic flag
    p_per_set_r4: assert property (@(posedge clk) disable iff (rst)
        per_wrap |=> per_flag);

    // R5: acknowledge without a coincident event clears the flag
    p_ovf_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_o && !ovf_wrap) |=> !ovf_flag);

    // R7: no periodic flag appears off the selected boundary
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        (!per_flag && !per_wrap) |=> !per_flag);

    // R6: a request never appears without its flag
    p_irq_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (!irq_ovf || ovf_flag) && (!irq_per || per_flag));

endmodule

bind mft_timer mft_timer_chk #(
    .PRE_W  (PRE_W),
    .LO_W   (LO_W),
    .HI_W   (HI_W),
    .RATE_W (RATE_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_sel  (reg_sel),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .chain    (chain_q),
    .ovf_flag (ovf_flag),
    .per_flag (per_flag),
    .rate     (rate_q),
    .irq_ovf  (irq_ovf),
    .irq_per  (irq_per)
);

// File: tb/mft_timer_test.sv
`timescale 1ns/1ps
module mft_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_ovf;
    logic       irq_per;

    int checks = 0;
    int errors = 0;
    int k = 0;

    always #10 clk = ~clk;

    mft_timer uut (
        .clk     (clk),
        .rst     (rst),
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_ovf (irq_ovf),
        .irq_per (irq_per)
    );

    // Vector table: edges since reset release, expected count, expected ovf flag
    localparam int  NV = 6;
    localparam int  VK [0:NV-1] = '{1, 4, 8, 1023, 1024, 1100};
    localparam int  VC [0:NV-1] = '{0, 1, 2, 255, 0, 19};
    localparam int  VO [0:NV-1] = '{0, 0, 0, 0, 1, 1};

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s at k=%0d: got %0h expected %0h", tag, k, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        k++;
        @(negedge clk);
    endtask

    task automatic adv_to(input int target);
        while (k < target) tick();
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_sel = 1'b0;
        wr_data = d;
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
    endtask

    initial begin
        #(199_000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog expired at k=%0d", k);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(1'b1, v); check("R1 count in reset", v, 0);
        rd(1'b0, v); check("R1 ctrl in reset", v, 0);
        check("R1 irq in reset", {irq_ovf, irq_per}, 0);
        rst = 1'b0;
        k = 0;

        for (int i = 0; i < NV; i++) begin
            adv_to(VK[i]);
            rd(1'b1, v); check("R2 count", v, VC[i]);
            rd(1'b0, v); check("R3 ovf flag", v[7], VO[i]);
        end

        wr(8'h20);
        check("R6 irq_ovf enabled", irq_ovf, 1);
        wr(8'h00);
        check("R6 irq_ovf disabled", irq_ovf, 0);
        rd(1'b0, v); check("R6 flag kept when enable cleared", v[7], 1);
        wr(8'h28);
        rd(1'b0, v); check("R5 ovf acked", v[7], 0);
        check("R5 irq after ack", irq_ovf, 0);

        adv_to(2047);
        rd(1'b0, v); check("R3 no ovf before boundary", v[7], 0);
        wr(8'h28);
        rd(1'b0, v); check("R5 event wins over ack", v, 8'hA0);
        check("R5 irq with event", irq_ovf, 1);
        check("R8 ack bits read 0", v[3:2], 0);

        adv_to(16383);
        rd(1'b0, v); check("R4 per clear at 16383", v[6], 0);
        tick();
        rd(1'b0, v); check("R4 per set at 2^14", v[6], 1);
        wr(8'h10);
        check("R6 irq_per enabled", irq_per, 1);
        wr(8'h16);
        rd(1'b0, v); check("R8 ctrl readback rate 2", v[5:0], 6'h12);
        check("R5 per acked", v[6], 0);

        adv_to(32770);
        rd(1'b0, v); check("R7 no flag at old-rate boundary", v[6], 0);
        adv_to(65535);
        rd(1'b0, v); check("R4 per clear at 65535", v[6], 0);
        tick();
        rd(1'b0, v); check("R4 per set at 2^16", v[6], 1);
        wr(8'h17);
        rd(1'b0, v); check("R8 rate 3 readback", v[1:0], 3);

        adv_to(98304);
        rd(1'b0, v); check("R7 no flag at 2^15 multiple", v[6], 0);
        adv_to(131071);
        rd(1'b0, v); check("R4 per clear at 131071", v[6], 0);
        tick();
        rd(1'b0, v); check("R4 per set at 2^17", v[6], 1);
        rd(1'b1, v); check("R2 count wrapped at 2^17", v, 0);
        wr(8'h15);

        adv_to(163839);
        rd(1'b0, v); check("R4 per clear before 2^15 step", v[6], 0);
        tick();
        rd(1'b0, v); check("R4 per set at rate 1 boundary", v[6], 1);
        check("R6 irq_per", irq_per, 1);

        rst = 1'b1;
        tick();
        rd(1'b1, v); check("R1 count cleared", v, 0);
        rd(1'b0, v); check("R1 ctrl cleared", v, 0);
        rst = 1'b0;
        k = 0;
        adv_to(9);
        rd(1'b1, v); check("R1 restart from zero", v, 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule